// File: doc/BRIEF.md
# Synchronization-Point L1 Coherence Controller

This block is the controller of a private, direct-mapped L1 data cache. It keeps the cache coherent with a shared L2 without a directory and without invalidation messages. It acts only at points that software signals. Outside a critical section the cache is an ordinary write-back cache. Software marks a critical section with a one-cycle `cs_enter` pulse and a one-cycle `cs_exit` pulse. Inside a critical section the cache does two extra things:
- Every store is also written to L2.
- The first load of each line is fetched again from L2. Later loads of that line in the same section are served from the local copy.

A barrier is a four-phase handshake on `bar_req` and `bar_done`. During a barrier the controller walks every line in index order:
- A dirty line is written back to L2.
- A line is invalidated unless software hints allow it to stay. A line may carry a read-only-shared hint or a private hint, and hints take effect only while `hint_en` is high.
- Processor requests wait until the walk has finished.

Each line holds one data word. Its address is {tag, index}. The processor holds a request until `cpu_done` pulses. The L2 side allows one transaction at a time.

Top module: `sync_l1_cache`

## Requirements
- R1: After reset every line is invalid and `cpu_done`, `bar_done` and `l2_req` are low, so the first load of any address reads L2.
- R2: Outside a critical section, a load that hits returns the local word with no L2 transaction, and a store that hits updates only the local copy (write-back).
- R3: Outside a critical section, a store that misses allocates the line without reading L2. A dirty line at the same index is first written to L2 at address {old tag, index}.
- R4: Inside a critical section, every store produces exactly one L2 write of the store data to the store address, and the local copy is updated to the stored value.
- R5: Inside a critical section, the first load of a line is read from L2 even when the tag matches. Later loads in the same section are local. A new `cs_enter` makes the next load read L2 again.
- R6: A dirty line that is refetched in a critical section is written back to L2 before it is read.
- R7: A barrier writes every dirty line back to L2 and writes no clean line. Afterwards every line without a retaining hint is invalid, so its next load reads L2.
- R8: While `hint_en` is high, a line whose hint has bit 0 set (read-only shared) or bit 1 set (private) stays valid across a barrier. Such a line is still written back if it is dirty. While `hint_en` is low, the hints have no effect. A line takes its hint from the access that last filled or wrote it.
- R9: A processor request raised during a barrier is not answered until the barrier ends. `bar_done` stays high for as long as `bar_req` stays high, and `cpu_done` and `bar_done` are never high together.
- R10: Only one L2 transaction is outstanding at a time. `l2_req`, `l2_we` and `l2_addr` hold steady until `l2_ack`, and each L2 access the controller needs is issued exactly once.
- R11: `cpu_done` is a one-cycle pulse. For a hit it comes on the second clock edge after the request is first sampled. For a fill it comes on the third edge when L2 acknowledges on the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Processor request, held until `cpu_done` |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | ADDR_W | Word address |
| cpu_wdata | input | DATA_W | Store data |
| cpu_hint | input | 2 | Bit 0 = read-only shared, bit 1 = private |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | DATA_W | Load data, valid with `cpu_done` |
| cs_enter | input | 1 | Critical-section entry pulse |
| cs_exit | input | 1 | Critical-section exit pulse |
| hint_en | input | 1 | Lets hints retain lines at a barrier |
| bar_req | input | 1 | Barrier request (level) |
| bar_done | output | 1 | Barrier finished, held while `bar_req` is high |
| l2_req | output | 1 | L2 transaction request |
| l2_we | output | 1 | L2 write (1) or read (0) |
| l2_addr | output | ADDR_W | L2 word address |
| l2_wdata | output | DATA_W | L2 write data |
| l2_ack | input | 1 | L2 acknowledge, one cycle |
| l2_rdata | input | DATA_W | L2 read data, valid with `l2_ack` |

## Verification
A load hit answers on the second edge after the request is sampled. A miss with a clean victim answers one edge after the L2 acknowledge. A dirty victim adds a write-back and a second decision cycle before the fill. The bench counts edges from the request to the `cpu_done` it observes and checks this count for hits and clean fills. It reads data and the L2 transaction counts only after `cpu_done` has been seen, on a falling edge, when all registered state has settled. For barriers it waits for `bar_done` before it compares the L2 contents and the write count. It then holds `bar_req` for several more cycles and checks that `bar_done` stays high.

// File: rtl/sync_l1_pkg.sv
package sync_l1_pkg;

    typedef struct packed {
        logic priv;       // bit 1: only this processor touches the line
        logic ro_shared;  // bit 0: shared but never written by anyone
    } hint_t;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DECIDE,
        ST_WB,
        ST_FILL,
        ST_WT,
        ST_RESP,
        ST_WALK,
        ST_WALK_WB,
        ST_BDONE
    } ctl_state_t;

    function automatic logic line_survives(input hint_t h, input logic en);
        return en && (h.priv || h.ro_shared);
    endfunction

endpackage

// File: rtl/sync_l1_lines.sv
module sync_l1_lines
    import sync_l1_pkg::*;
#(
    parameter int LINES  = 8,
    parameter int TAG_W  = 3,
    parameter int DATA_W = 16,
    localparam int IDX_W = $clog2(LINES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr_fetched,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic              rd_valid,
    output logic              rd_dirty,
    output logic              rd_fetched,
    output logic [TAG_W-1:0]  rd_tag,
    output logic [DATA_W-1:0] rd_data,
    output hint_t             rd_hint,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic              wr_valid,
    input  logic              wr_dirty,
    input  logic              wr_fetched,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [DATA_W-1:0] wr_data,
    input  hint_t             wr_hint
);

    typedef struct packed {
        logic              valid;
        logic              dirty;
        logic              fetched;
        hint_t             hint;
        logic [TAG_W-1:0]  tag;
        logic [DATA_W-1:0] data;
    } entry_t;

    entry_t lines_q [LINES];
    entry_t rd_e;

    assign rd_e       = lines_q[rd_idx];
    assign rd_valid   = rd_e.valid;
    assign rd_dirty   = rd_e.dirty;
    assign rd_fetched = rd_e.fetched;
    assign rd_tag     = rd_e.tag;
    assign rd_data    = rd_e.data;
    assign rd_hint    = rd_e.hint;

    // One generated slot per line; a write to this slot takes precedence over
    // the section-wide clear of the first-touch bit.
    for (genvar gi = 0; gi < LINES; gi++) begin : g_line
        always_ff @(posedge clk) begin
            if (rst) begin
                lines_q[gi] <= '0;
            end else if (wr_en && wr_idx == IDX_W'(gi)) begin
                lines_q[gi] <= '{valid: wr_valid, dirty: wr_dirty, fetched: wr_fetched,
                                 hint: wr_hint, tag: wr_tag, data: wr_data};
            end else if (clr_fetched) begin
                lines_q[gi].fetched <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/sync_l1_ctrl.sv
module sync_l1_ctrl
    import sync_l1_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 16,
    parameter int LINES  = 8,
    localparam int IDX_W = $clog2(LINES),
    localparam int TAG_W = ADDR_W - IDX_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    input  hint_t             cpu_hint,
    output logic              cpu_done,
    output logic [DATA_W-1:0] cpu_rdata,
    input  logic              cs_enter,
    input  logic              cs_exit,
    input  logic              hint_en,
    input  logic              bar_req,
    output logic              bar_done,
    output logic              l2_req,
    output logic              l2_we,
    output logic [ADDR_W-1:0] l2_addr,
    output logic [DATA_W-1:0] l2_wdata,
    input  logic              l2_ack,
    input  logic [DATA_W-1:0] l2_rdata,
    // line store access
    output logic              clr_fetched,
    output logic [IDX_W-1:0]  rd_idx,
    input  logic              rd_valid,
    input  logic              rd_dirty,
    input  logic              rd_fetched,
    input  logic [TAG_W-1:0]  rd_tag,
    input  logic [DATA_W-1:0] rd_data,
    input  hint_t             rd_hint,
    output logic              wr_en,
    output logic [IDX_W-1:0]  wr_idx,
    output logic              wr_valid,
    output logic              wr_dirty,
    output logic              wr_fetched,
    output logic [TAG_W-1:0]  wr_tag,
    output logic [DATA_W-1:0] wr_data,
    output hint_t             wr_hint
);

    ctl_state_t        state_q, state_d;
    logic              in_cs_q;
    logic              op_we_q;
    logic [ADDR_W-1:0] op_addr_q;
    logic [DATA_W-1:0] op_wdata_q;
    hint_t             op_hint_q;
    logic [DATA_W-1:0] rdata_q, rdata_d;
    logic              rdata_ld;
    logic [IDX_W-1:0]  walk_idx_q;
    logic              walk_adv;

    logic [IDX_W-1:0]  op_idx;
    logic [TAG_W-1:0]  op_tag;
    logic              walking, tag_hit, walk_last, keep;

    assign op_idx    = op_addr_q[IDX_W-1:0];
    assign op_tag    = op_addr_q[ADDR_W-1:IDX_W];
    assign walking   = (state_q == ST_WALK) || (state_q == ST_WALK_WB);
    assign rd_idx    = walking ? walk_idx_q : op_idx;
    assign tag_hit   = rd_valid && (rd_tag == op_tag);
    assign walk_last = (walk_idx_q == IDX_W'(LINES - 1));
    assign keep      = line_survives(rd_hint, hint_en);

    assign clr_fetched = cs_enter;
    assign cpu_done    = (state_q == ST_RESP);
    assign cpu_rdata   = rdata_q;
    assign bar_done    = (state_q == ST_BDONE);

    // L2 port: victim traffic uses the stored tag, own traffic the request address
    always_comb begin
        l2_req   = 1'b0;
        l2_we    = 1'b1;
        l2_addr  = op_addr_q;
        l2_wdata = op_wdata_q;
        unique case (state_q)
            ST_WB, ST_WALK_WB: begin
                l2_req   = 1'b1;
                l2_addr  = {rd_tag, rd_idx};
                l2_wdata = rd_data;
            end
            ST_FILL: begin
                l2_req = 1'b1;
                l2_we  = 1'b0;
            end
            ST_WT:   l2_req = 1'b1;
            default: ;
        endcase
    end

    always_comb begin
        state_d    = state_q;
        rdata_ld   = 1'b0;
        rdata_d    = rd_data;
        walk_adv   = 1'b0;
        wr_en      = 1'b0;
        wr_idx     = rd_idx;
        wr_valid   = rd_valid;
        wr_dirty   = rd_dirty;
        wr_fetched = rd_fetched;
        wr_tag     = rd_tag;
        wr_data    = rd_data;
        wr_hint    = rd_hint;
        unique case (state_q)
            ST_IDLE: begin
                if (bar_req)      state_d = ST_WALK;
                else if (cpu_req) state_d = ST_DECIDE;
            end
            ST_DECIDE: begin
                if (!op_we_q) begin
                    if (tag_hit && (!in_cs_q || rd_fetched)) begin
                        rdata_ld = 1'b1;
                        state_d  = ST_RESP;
                    end else if (rd_valid && rd_dirty) begin
                        state_d = ST_WB;
                    end else begin
                        state_d = ST_FILL;
                    end
                end else if (rd_valid && rd_dirty && !tag_hit) begin
                    state_d = ST_WB;
                end else if (in_cs_q) begin
                    state_d = ST_WT;
                end else begin
                    wr_en      = 1'b1;
                    wr_valid   = 1'b1;
                    wr_dirty   = 1'b1;
                    wr_fetched = 1'b1;
                    wr_tag     = op_tag;
                    wr_data    = op_wdata_q;
                    wr_hint    = op_hint_q;
                    state_d    = ST_RESP;
                end
            end
            ST_WB: begin
                if (l2_ack) begin
                    wr_en    = 1'b1;
                    wr_dirty = 1'b0;
                    state_d  = ST_DECIDE;
                end
            end
            ST_FILL, ST_WT: begin
                if (l2_ack) begin
                    wr_en      = 1'b1;
                    wr_valid   = 1'b1;
                    wr_dirty   = 1'b0;
                    wr_fetched = 1'b1;
                    wr_tag     = op_tag;
                    wr_data    = (state_q == ST_FILL) ? l2_rdata : op_wdata_q;
                    wr_hint    = op_hint_q;
                    rdata_ld   = (state_q == ST_FILL);
                    rdata_d    = l2_rdata;
                    state_d    = ST_RESP;
                end
            end
            ST_RESP: state_d = ST_IDLE;
            ST_WALK: begin
                if (rd_valid && rd_dirty) begin
                    state_d = ST_WALK_WB;
                end else begin
                    wr_en    = 1'b1;
                    wr_valid = rd_valid && keep;
                    wr_dirty = 1'b0;
                    walk_adv = 1'b1;
                    state_d  = walk_last ? ST_BDONE : ST_WALK;
                end
            end
            ST_WALK_WB: begin
                if (l2_ack) begin
                    wr_en    = 1'b1;
                    wr_valid = keep;
                    wr_dirty = 1'b0;
                    walk_adv = 1'b1;
                    state_d  = walk_last ? ST_BDONE : ST_WALK;
                end
            end
            ST_BDONE: begin
                if (!bar_req) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_IDLE;
            in_cs_q    <= 1'b0;
            op_we_q    <= 1'b0;
            op_addr_q  <= '0;
            op_wdata_q <= '0;
            op_hint_q  <= '0;
            rdata_q    <= '0;
            walk_idx_q <= '0;
        end else begin
            state_q <= state_d;
            if (cs_enter)     in_cs_q <= 1'b1;
            else if (cs_exit) in_cs_q <= 1'b0;
            if (state_q == ST_IDLE && !bar_req && cpu_req) begin
                op_we_q    <= cpu_we;
                op_addr_q  <= cpu_addr;
                op_wdata_q <= cpu_wdata;
                op_hint_q  <= cpu_hint;
            end
            if (rdata_ld) rdata_q <= rdata_d;
            if (state_q == ST_IDLE) walk_idx_q <= '0;
            else if (walk_adv)      walk_idx_q <= walk_idx_q + 1'b1;
        end
    end

endmodule

// File: rtl/sync_l1_cache.sv
module sync_l1_cache
    import sync_l1_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 16,
    parameter int LINES  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    input  logic [1:0]        cpu_hint,
    output logic              cpu_done,
    output logic [DATA_W-1:0] cpu_rdata,
    input  logic              cs_enter,
    input  logic              cs_exit,
    input  logic              hint_en,
    input  logic              bar_req,
    output logic              bar_done,
    output logic              l2_req,
    output logic              l2_we,
    output logic [ADDR_W-1:0] l2_addr,
    output logic [DATA_W-1:0] l2_wdata,
    input  logic              l2_ack,
    input  logic [DATA_W-1:0] l2_rdata
);

    localparam int IDX_W = $clog2(LINES);
    localparam int TAG_W = ADDR_W - IDX_W;

    logic              clr_fetched;
    logic [IDX_W-1:0]  rd_idx, wr_idx;
    logic              rd_valid, rd_dirty, rd_fetched;
    logic [TAG_W-1:0]  rd_tag, wr_tag;
    logic [DATA_W-1:0] rd_data, wr_data;
    hint_t             rd_hint, wr_hint, hint_in;
    logic              wr_en, wr_valid, wr_dirty, wr_fetched;

    assign hint_in = hint_t'(cpu_hint);

    sync_l1_lines #(.LINES(LINES), .TAG_W(TAG_W), .DATA_W(DATA_W)) lines_i (
        .clk, .rst, .clr_fetched,
        .rd_idx, .rd_valid, .rd_dirty, .rd_fetched, .rd_tag, .rd_data, .rd_hint,
        .wr_en, .wr_idx, .wr_valid, .wr_dirty, .wr_fetched, .wr_tag, .wr_data, .wr_hint
    );

    sync_l1_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINES(LINES)) ctrl_i (
        .clk, .rst,
        .cpu_req, .cpu_we, .cpu_addr, .cpu_wdata, .cpu_hint(hint_in),
        .cpu_done, .cpu_rdata,
        .cs_enter, .cs_exit, .hint_en, .bar_req, .bar_done,
        .l2_req, .l2_we, .l2_addr, .l2_wdata, .l2_ack, .l2_rdata,
        .clr_fetched, .rd_idx, .rd_valid, .rd_dirty, .rd_fetched, .rd_tag, .rd_data,
        .rd_hint, .wr_en, .wr_idx, .wr_valid, .wr_dirty, .wr_fetched, .wr_tag,
        .wr_data, .wr_hint
    );

endmodule

// File: rtl/sync_l1_cache_chk.sv
module sync_l1_cache_chk #(
    parameter int ADDR_W = 6
) (
    input logic              clk,
    input logic              rst,
    input logic              cpu_done,
    input logic              bar_req,
    input logic              bar_done,
    input logic              l2_req,
    input logic              l2_ack,
    input logic              l2_we,
    input logic [ADDR_W-1:0] l2_addr
);

    assert_l2_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (l2_req && !l2_ack) |=> (l2_req && $stable(l2_addr) && $stable(l2_we)));

    assert_done_pulse_R11: assert property (@(posedge clk) disable iff (rst)
        cpu_done |=> !cpu_done);

    assert_no_serve_in_barrier_R9: assert property (@(posedge clk) disable iff (rst)
        !(cpu_done && bar_done));

    assert_bar_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (bar_done && bar_req) |=> bar_done);

    assert_quiet_after_walk_R7: assert property (@(posedge clk) disable iff (rst)
        bar_done |-> !l2_req);

endmodule

bind sync_l1_cache sync_l1_cache_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk(clk), .rst(rst), .cpu_done(cpu_done), .bar_req(bar_req),
    .bar_done(bar_done), .l2_req(l2_req), .l2_ack(l2_ack), .l2_we(l2_we),
    .l2_addr(l2_addr)
);

// File: tb/sync_l1_cache_tb_top.sv
`timescale 1ns/1ps
module sync_l1_cache_tb_top;

    localparam int ADDR_W = 6;
    localparam int DATA_W = 16;
    localparam int LINES  = 8;
    localparam int NADDR  = 1 << ADDR_W;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              cpu_req = 1'b0, cpu_we = 1'b0;
    logic [ADDR_W-1:0] cpu_addr = '0;
    logic [DATA_W-1:0] cpu_wdata = '0;
    logic [1:0]        cpu_hint = '0;
    logic              cpu_done;
    logic [DATA_W-1:0] cpu_rdata;
    logic              cs_enter = 1'b0, cs_exit = 1'b0, hint_en = 1'b0, bar_req = 1'b0;
    logic              bar_done;
    logic              l2_req, l2_we;
    logic [ADDR_W-1:0] l2_addr;
    logic [DATA_W-1:0] l2_wdata;
    logic              l2_ack;
    logic [DATA_W-1:0] l2_rdata;

    logic [DATA_W-1:0] l2mem [NADDR];
    int rd_cnt, wr_cnt;
    int nvec = 0, nfail = 0, cycles = 0;
    int refv [NADDR];

    always #2.5 clk = ~clk;

    sync_l1_cache #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINES(LINES)) dut_i (.*);

    function automatic int init_word(input int a);
        return (a * 7 + 3) & 16'hFFFF;
    endfunction

    // L2 model: acknowledges one half-cycle after seeing a request
    always @(negedge clk) begin
        if (rst) begin
            l2_ack   <= 1'b0;
            l2_rdata <= '0;
            rd_cnt   <= 0;
            wr_cnt   <= 0;
            for (int a = 0; a < NADDR; a++) l2mem[a] <= DATA_W'(init_word(a));
        end else if (l2_req && !l2_ack) begin
            l2_ack <= 1'b1;
            if (l2_we) begin
                l2mem[l2_addr] <= l2_wdata;
                wr_cnt <= wr_cnt + 1;
            end else begin
                l2_rdata <= l2mem[l2_addr];
                rd_cnt   <= rd_cnt + 1;
            end
        end else begin
            l2_ack <= 1'b0;
        end
    end

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
            $display("== %0d vectors applied, %0d miscompares ==", nvec + 1, nfail + 1);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        nvec++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic access(input bit we, input int addr, input int wd, input logic [1:0] h,
                          output int rd, output int cyc, output int dr, output int dw);
        int r0, w0;
        @(negedge clk);
        r0 = rd_cnt; w0 = wr_cnt;
        cpu_req = 1'b1; cpu_we = we; cpu_addr = ADDR_W'(addr);
        cpu_wdata = DATA_W'(wd); cpu_hint = h;
        cyc = 0;
        do begin
            @(negedge clk);
            cyc++;
        end while (!cpu_done && cyc < 60);
        rd = int'(cpu_rdata);
        cpu_req = 1'b0;
        dr = rd_cnt - r0;
        dw = wr_cnt - w0;
    endtask

    task automatic cs_pulse(input bit enter);
        @(negedge clk);
        if (enter) cs_enter = 1'b1; else cs_exit = 1'b1;
        @(negedge clk);
        cs_enter = 1'b0; cs_exit = 1'b0;
    endtask

    task automatic barrier(output int dw);
        int w0, n;
        @(negedge clk);
        w0 = wr_cnt;
        bar_req = 1'b1;
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!bar_done && n < 200);
        dw = wr_cnt - w0;
        bar_req = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        int rd, cyc, dr, dw, n;
        bit early;
        repeat (3) @(negedge clk);
        chk(cpu_done == 1'b0, "R1 cpu_done in reset", int'(cpu_done), 0);
        chk(bar_done == 1'b0, "R1 bar_done in reset", int'(bar_done), 0);
        chk(l2_req == 1'b0, "R1 l2_req in reset", int'(l2_req), 0);
        rst = 1'b0;
        hint_en = 1'b1;

        // first load after reset: fill from L2
        access(0, 5, 0, 2'b00, rd, cyc, dr, dw);
        chk(rd == init_word(5), "R1 fill data", rd, init_word(5));
        chk(dr == 1, "R1 first load reads L2", dr, 1);
        chk(cyc == 3, "R11 fill latency", cyc, 3);
        access(0, 5, 0, 2'b00, rd, cyc, dr, dw);
        chk(rd == init_word(5), "R2 hit data", rd, init_word(5));
        chk(dr == 0 && dw == 0, "R2 hit no L2", dr + dw, 0);
        chk(cyc == 2, "R11 hit latency", cyc, 2);

        // write-back store hit
        access(1, 5, 16'h1234, 2'b00, rd, cyc, dr, dw);
        chk(dr == 0 && dw == 0, "R2 store hit no L2", dr + dw, 0);
        chk(int'(l2mem[5]) == init_word(5), "R2 L2 untouched", int'(l2mem[5]), init_word(5));
        access(0, 5, 0, 2'b00, rd, cyc, dr, dw);
        chk(rd == 16'h1234, "R2 reads stored word", rd, 16'h1234);

        // store miss on a dirty index: victim written back, no fetch
        access(1, 13, 16'h0BEE, 2'b00, rd, cyc, dr, dw);
        chk(dw == 1, "R3 victim write-back", dw, 1);
        chk(dr == 0, "R3 no fetch on store miss", dr, 0);
        chk(int'(l2mem[5]) == 16'h1234, "R3 victim data", int'(l2mem[5]), 16'h1234);
        access(0, 13, 0, 2'b00, rd, cyc, dr, dw);
        chk(rd == 16'h0BEE && dr == 0, "R3 allocated line", rd, 16'h0BEE);

        // critical section: dirty refetch, then local
        cs_pulse(1);
        access(0, 13, 0, 2'b00, rd, cyc, dr, dw);
        chk(dw == 1 && dr == 1, "R6 write-back then fill", dw * 10 + dr, 11);
        chk(int'(l2mem[13]) == 16'h0BEE, "R6 written-back data", int'(l2mem[13]), 16'h0BEE);
        chk(rd == 16'h0BEE, "R6 refetched data", rd, 16'h0BEE);
        access(0, 13, 0, 2'b00, rd, cyc, dr, dw);
        chk(dr == 0 && dw == 0, "R5 second load local", dr + dw, 0);

        // critical-section store is written through
        access(1, 21, 16'h2121, 2'b00, rd, cyc, dr, dw);
        chk(dw == 1 && dr == 0, "R4 one L2 write", dw * 10 + dr, 10);
        chk(int'(l2mem[21]) == 16'h2121, "R4 L2 data", int'(l2mem[21]), 16'h2121);
        access(0, 21, 0, 2'b00, rd, cyc, dr, dw);
        chk(rd == 16'h2121 && dr == 0, "R4 local updated", rd, 16'h2121);

        // new section forces refetch
        cs_pulse(0);
        cs_pulse(1);
        access(0, 21, 0, 2'b00, rd, cyc, dr, dw);
        chk(dr == 1, "R5 new section refetch", dr, 1);
        cs_pulse(0);
        access(0, 21, 0, 2'b00, rd, cyc, dr, dw);
        chk(dr == 0, "R2 outside section local", dr, 0);

        // sweep: store every address, read back in reverse
        for (int a = 0; a < NADDR; a++) begin
            refv[a] = (a * 37 + 11) & 16'hFFFF;
            access(1, a, refv[a], 2'b00, rd, cyc, dr, dw);
            chk(dr == 0, "R3 sweep store no fetch", dr, 0);
        end
        for (int a = NADDR - 1; a >= 0; a--) begin
            access(0, a, 0, 2'b00, rd, cyc, dr, dw);
            chk(rd == refv[a], "R3 sweep readback", rd, refv[a]);
        end
        hint_en = 1'b0;
        barrier(dw);
        for (int a = 0; a < NADDR; a++)
            chk(int'(l2mem[a]) == refv[a], "R7 flushed contents", int'(l2mem[a]), refv[a]);
        access(0, 0, 0, 2'b00, rd, cyc, dr, dw);
        chk(dr == 1, "R7 invalid after barrier", dr, 1);
        barrier(dw);
        chk(dw == 0, "R7 clean lines not written", dw, 0);

        // hints with a processor request pending during the barrier
        hint_en = 1'b1;
        access(1, 0, 16'h00A0, 2'b01, rd, cyc, dr, dw);
        access(0, 1, 0, 2'b10, rd, cyc, dr, dw);
        access(1, 2, 16'h00A2, 2'b00, rd, cyc, dr, dw);
        access(0, 3, 0, 2'b00, rd, cyc, dr, dw);
        @(negedge clk);
        begin
            int w0, r0;
            w0 = wr_cnt; r0 = rd_cnt;
            bar_req = 1'b1;
            cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = '0; cpu_hint = 2'b01;
            early = 1'b0; n = 0;
            do begin
                @(negedge clk);
                n++;
                if (cpu_done) early = 1'b1;
            end while (!bar_done && n < 200);
            chk(!early, "R9 request stalled in walk", int'(early), 0);
            chk(wr_cnt - w0 == 2, "R7 dirty lines written", wr_cnt - w0, 2);
            for (int k = 0; k < 3; k++) begin
                @(negedge clk);
                chk(bar_done == 1'b1, "R9 done held", int'(bar_done), 1);
                chk(cpu_done == 1'b0, "R9 no reply while held", int'(cpu_done), 0);
            end
            bar_req = 1'b0;
            n = 0;
            do begin
                @(negedge clk);
                n++;
            end while (!cpu_done && n < 60);
            chk(int'(cpu_rdata) == 16'h00A0, "R8 kept line data", int'(cpu_rdata), 16'h00A0);
            chk(rd_cnt - r0 == 0, "R8 read-only line kept", rd_cnt - r0, 0);
            cpu_req = 1'b0;
        end
        chk(int'(l2mem[0]) == 16'h00A0, "R8 dirty kept line written", int'(l2mem[0]), 16'h00A0);
        chk(int'(l2mem[2]) == 16'h00A2, "R7 dirty line written", int'(l2mem[2]), 16'h00A2);
        access(0, 1, 0, 2'b10, rd, cyc, dr, dw);
        chk(dr == 0, "R8 private line kept", dr, 0);
        access(0, 2, 0, 2'b00, rd, cyc, dr, dw);
        chk(dr == 1 && rd == 16'h00A2, "R7 unhinted dirty invalidated", dr, 1);
        access(0, 3, 0, 2'b00, rd, cyc, dr, dw);
        chk(dr == 1, "R7 unhinted clean invalidated", dr, 1);
        chk(dw == 0, "R10 fill issues no write", dw, 0);

        // hints ignored when disabled
        access(1, 0, 16'h00B0, 2'b01, rd, cyc, dr, dw);
        hint_en = 1'b0;
        barrier(dw);
        chk(dw == 1, "R10 single write-back per dirty line", dw, 1);
        access(0, 0, 0, 2'b01, rd, cyc, dr, dw);
        chk(dr == 1, "R8 hint disabled invalidates", dr, 1);
        chk(rd == 16'h00B0, "R8 data after refetch", rd, 16'h00B0);

        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

endmodule